// File: doc/BRIEF.md
# Pre-Bias Synchronous Rectifier Ramp-In Controller

This block decides when a buck converter may start switching after power-up and how wide the low-side (synchronous rectifier) on-time may be while the output settles. The output may already be charged to some voltage before startup. If the low-side switch were given its full on-time at once, it would pull current back out of that charged output. To avoid this, the block keeps switching off until an external comparator reports that the soft-start reference has risen above the feedback voltage. It then hands a very narrow low-side on-time to the modulator and widens it one count per switching cycle until it meets the steady-state (1-D) value.

A downstream modulator reads `pwm_en` and `ls_on_time` and uses them as its switching permit and its low-side pulse width in clock counts. The target on-time is an input, so the controller that computes 1-D can keep changing it. The block never lets the on-time exceed the target. Every input is a plain control level or a single-cycle strobe, and every output is a registered level, so there is no handshake and no back-pressure. All three outputs change only on the rising clock edge after the input that causes the change.

Top module: `srramp_top`

## Requirements
- R1: After reset, or after a restart, `pwm_en`, `ls_on_time` and `ramp_done` are all 0. They stay 0, whatever `cycle_tick` does, until `ss_above_fb` is sampled high.
- R2: On the first clock edge where `ss_above_fb` is sampled high in the gated state, `pwm_en` becomes 1 and `ls_on_time` becomes the smaller of 1 and `target_on`.
- R3: While the ramp is running, `ls_on_time` rises by exactly 1 on each clock edge where `cycle_tick` is high. On edges where `cycle_tick` is low, it does not change.
- R4: An increment never carries `ls_on_time` above `target_on`. `ramp_done` rises on the same edge where `ls_on_time` first equals `target_on`, and further ticks leave the value at the target.
- R5: While the ramp is running, if `target_on` is below `ls_on_time`, then on the next edge `ls_on_time` equals `target_on` and `ramp_done` is 1. This clamp takes priority over a tick in the same cycle.
- R6: Once `ramp_done` is 1, `ls_on_time` follows `target_on` with one clock of delay, and `ramp_done` stays 1.
- R7: `restart` is synchronous and outranks every other input. On the next edge it returns all outputs to 0, including when `ss_above_fb` is high in the same cycle.
- R8: After release, deasserting `ss_above_fb` has no effect. `pwm_en` stays 1 and the ramp continues.
- R9: If `target_on` is 0 at release, then on the release edge `pwm_en` is 1, `ls_on_time` is 0 and `ramp_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to the gated state |
| ss_above_fb | input | 1 | Comparator flag: soft-start reference above feedback |
| cycle_tick | input | 1 | One-clock strobe per switching cycle |
| target_on | input | ON_W | Steady-state low-side on-time in clock counts |
| pwm_en | output | 1 | Switching permitted |
| ls_on_time | output | ON_W | Low-side on-time currently granted, in counts |
| ramp_done | output | 1 | On-time has reached the target |

## Verification
The bench sends `cycle_tick` pulses before release. A design that let the gate open early, or that counted ticks while gated, would show a nonzero on-time or a raised enable there. During the ramp, the bench checks the value after every tick and after clock cycles with no tick. This catches steps larger than one, counting on every clock, and an overshoot past the target on the last step. A lowered target in mid-ramp tests the clamp: a design that only stopped growing would keep the old, larger width. Three further cases cover the remaining rules. A restart raised together with `ss_above_fb` must still gate. A zero target at release must produce a finished ramp at once. Dropping `ss_above_fb` after release must not re-gate the output.

// File: rtl/srramp_pkg.sv
package srramp_pkg;
  typedef enum logic [1:0] {
    PH_GATED = 2'd0,
    PH_RAMP  = 2'd1,
    PH_HOLD  = 2'd2
  } phase_t;
endpackage

// File: rtl/srramp_phase_fsm.sv
module srramp_phase_fsm
  import srramp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   ss_above_fb,
  input  logic   reached,
  output phase_t phase,
  output logic   entering
);
  phase_t phase_q, phase_d;

  assign entering = (phase_q == PH_GATED) && ss_above_fb && !restart;

  always_comb begin
    phase_d = phase_q;
    if (restart) begin
      phase_d = PH_GATED;
    end else begin
      unique case (phase_q)
        PH_GATED: if (ss_above_fb) phase_d = reached ? PH_HOLD : PH_RAMP;
        PH_RAMP:  if (reached)     phase_d = PH_HOLD;
        PH_HOLD:  phase_d = PH_HOLD;
        default:  phase_d = PH_GATED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_GATED;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/srramp_step.sv
module srramp_step
  import srramp_pkg::*;
#(
  parameter int ON_W  = 10,
  parameter int START = 1,
  parameter int STEP  = 1
) (
  input  phase_t           phase,
  input  logic             entering,
  input  logic             tick,
  input  logic [ON_W-1:0]  cur,
  input  logic [ON_W-1:0]  target,
  output logic [ON_W-1:0]  next_on,
  output logic             reached
);
  localparam logic [ON_W-1:0] START_W = ON_W'(START);
  localparam logic [ON_W-1:0] STEP_W  = ON_W'(STEP);

  logic [ON_W-1:0] gap;
  assign gap = target - cur;

  always_comb begin
    next_on = '0;
    reached = 1'b0;
    if (entering) begin
      next_on = (START_W > target) ? target : START_W;
      reached = (next_on == target);
    end else begin
      unique case (phase)
        PH_RAMP: begin
          if (cur > target)              next_on = target;
          else if (tick && cur < target) next_on = (gap < STEP_W) ? target : cur + STEP_W;
          else                           next_on = cur;
          reached = (next_on == target);
        end
        PH_HOLD:  next_on = target;
        default:  next_on = '0;
      endcase
    end
  end
endmodule

// File: rtl/srramp_top.sv
module srramp_top
  import srramp_pkg::*;
#(
  parameter int ON_W  = 10,
  parameter int START = 1,
  parameter int STEP  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            ss_above_fb,
  input  logic            cycle_tick,
  input  logic [ON_W-1:0] target_on,
  output logic            pwm_en,
  output logic [ON_W-1:0] ls_on_time,
  output logic            ramp_done
);
  phase_t          phase;
  logic            entering;
  logic            reached;
  logic [ON_W-1:0] next_on;
  logic [ON_W-1:0] on_q;

  srramp_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .ss_above_fb (ss_above_fb),
    .reached     (reached),
    .phase       (phase),
    .entering    (entering)
  );

  srramp_step #(.ON_W(ON_W), .START(START), .STEP(STEP)) u_step (
    .phase    (phase),
    .entering (entering),
    .tick     (cycle_tick),
    .cur      (on_q),
    .target   (target_on),
    .next_on  (next_on),
    .reached  (reached)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       on_q <= '0;
    else if (restart) on_q <= '0;
    else              on_q <= next_on;
  end

  assign pwm_en     = (phase != PH_GATED);
  assign ramp_done  = (phase == PH_HOLD);
  assign ls_on_time = on_q;
endmodule

// File: rtl/srramp_checker.sv
module srramp_checker #(
  parameter int ON_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            restart,
  input logic            ss_above_fb,
  input logic            cycle_tick,
  input logic [ON_W-1:0] target_on,
  input logic            pwm_en,
  input logic [ON_W-1:0] ls_on_time,
  input logic            ramp_done
);
  localparam logic [ON_W:0] ONE = (ON_W+1)'(1);

  a_r1_stay_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en && !ss_above_fb) |=> (!pwm_en && ls_on_time == '0));

  a_r1_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |-> (ls_on_time == '0 && !ramp_done));

  a_r2_narrow_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> ({1'b0, ls_on_time} <= ONE));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !ramp_done && !restart) |=>
      ({1'b0, ls_on_time} <= {1'b0, $past(ls_on_time)} + ONE));

  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !ramp_done && !restart && !cycle_tick) |=>
      (ls_on_time <= $past(ls_on_time)));

  a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !restart && ls_on_time > target_on) |=>
      (ls_on_time == $past(target_on) && ramp_done));

  a_r4_done_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_done) |-> (ls_on_time == $past(target_on)));

  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done && !restart) |=> (ramp_done && ls_on_time == $past(target_on)));

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!pwm_en && !ramp_done && ls_on_time == '0));

  a_r8_stay_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !restart) |=> pwm_en);
endmodule

bind srramp_top srramp_checker #(.ON_W(ON_W)) u_srramp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .ss_above_fb (ss_above_fb),
  .cycle_tick  (cycle_tick),
  .target_on   (target_on),
  .pwm_en      (pwm_en),
  .ls_on_time  (ls_on_time),
  .ramp_done   (ramp_done)
);

// File: tb/srramp_top_bench.sv
`timescale 1ns/1ps
module srramp_top_bench;
  localparam int ON_W = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            restart = 1'b0;
  logic            ss_above_fb = 1'b0;
  logic            cycle_tick = 1'b0;
  logic [ON_W-1:0] target_on = '0;
  logic            pwm_en;
  logic [ON_W-1:0] ls_on_time;
  logic            ramp_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  srramp_top #(.ON_W(ON_W)) u_srramp_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .ss_above_fb (ss_above_fb),
    .cycle_tick  (cycle_tick),
    .target_on   (target_on),
    .pwm_en      (pwm_en),
    .ls_on_time  (ls_on_time),
    .ramp_done   (ramp_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int en, input int on, input int dn);
    chk({req, " pwm_en"}, int'(pwm_en), en);
    chk({req, " ls_on_time"}, int'(ls_on_time), on);
    chk({req, " ramp_done"}, int'(ramp_done), dn);
  endtask

  // Called at a negedge: apply tick, pass one rising edge, return at the next negedge
  task automatic cyc(input logic tk);
    cycle_tick = tk;
    @(negedge clk);
    cycle_tick = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    cyc(1'b0);
    restart = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_out("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    cyc(1'b0);
    chk_out("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_gated();
    target_on = 10'd7;
    ss_above_fb = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1);
      chk_out("R1 tick while gated", 0, 0, 0);
    end
  endtask

  task automatic t_ramp();
    target_on = 10'd5;
    ss_above_fb = 1'b1;
    cyc(1'b0);
    chk_out("R2 release", 1, 1, 0);
    ss_above_fb = 1'b0;
    for (int i = 2; i <= 5; i++) begin
      cyc(1'b1);
      chk_out("R3 step", 1, i, (i == 5) ? 1 : 0);
      if (i == 2) begin
        cyc(1'b0);
        chk_out("R3 no tick", 1, 2, 0);
      end
    end
    cyc(1'b1);
    chk_out("R4 no overshoot", 1, 5, 1);
  endtask

  task automatic t_follow();
    target_on = 10'd9;
    cyc(1'b0);
    chk_out("R6 follow up", 1, 9, 1);
    target_on = 10'd3;
    cyc(1'b1);
    chk_out("R6 follow down", 1, 3, 1);
  endtask

  task automatic t_restart();
    ss_above_fb = 1'b1;
    do_restart();
    chk_out("R7 restart beats ss", 0, 0, 0);
    target_on = 10'd4;
    cyc(1'b0);
    chk_out("R2 release after restart", 1, 1, 0);
    ss_above_fb = 1'b0;
    cyc(1'b1);
    chk_out("R8 ss drop keeps ramp", 1, 2, 0);
    cyc(1'b0);
    chk_out("R8 ss drop keeps enable", 1, 2, 0);
    restart = 1'b1;
    cyc(1'b1);
    restart = 1'b0;
    chk_out("R7 restart mid ramp", 0, 0, 0);
  endtask

  task automatic t_clamp();
    target_on = 10'd20;
    ss_above_fb = 1'b1;
    cyc(1'b0);
    ss_above_fb = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1);
    chk_out("R3 ramp to 4", 1, 4, 0);
    target_on = 10'd2;
    cyc(1'b1);
    chk_out("R5 clamp", 1, 2, 1);
  endtask

  task automatic t_zero();
    do_restart();
    target_on = 10'd0;
    ss_above_fb = 1'b1;
    cyc(1'b0);
    chk_out("R9 zero target", 1, 0, 1);
    ss_above_fb = 1'b0;
  endtask

  task automatic t_reach_on_entry();
    do_restart();
    target_on = 10'd1;
    ss_above_fb = 1'b1;
    cyc(1'b1);
    chk_out("R4 target one at release", 1, 1, 1);
    ss_above_fb = 1'b0;
  endtask

  initial begin
    t_reset();
    t_gated();
    t_ramp();
    t_follow();
    t_restart();
    t_clamp();
    t_zero();
    t_reach_on_entry();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule